// File: doc/BRIEF.md
# Self-Clocked Serial Configuration Source with Chain-Head Role

This block is a serial configuration bit source that can lead a daisy chain. While the output-enable input is low it holds everything quiet and watches the chip-select level. When output-enable rises, that level fixes its role. If chip-select was low, the block is the chain head. It divides the system clock to make the configuration clock and drives that clock to the target and to every downstream source. It shifts out its own stored bits one per rising edge. When its bits run out it pulls its cascade output low to wake the next source, and it keeps clocking. If chip-select was high, the block is a downstream member. It never drives the clock. It waits until its chip-select is pulled low, then shifts a bit on each rising edge of the clock it receives.

The target raises the head's chip-select when it has finished loading. If all of the head's own bits have gone out by then, the head issues a fixed burst of extra clocks and then parks the clock low in an idle state. If chip-select rises while the head still holds unsent bits, the head stops clocking and asserts an open-drain error pull-down. The next output-enable reset clears that error. The stored bits sit in an external one-bit-wide array, which the block addresses through a read port. Output-enable and chip-select are synchronous to the system clock. The received clock is treated as asynchronous and is synchronised before use.

Top module: `cfg_chain_head`

## Requirements
- R1: The level of cs_n_i in the last cycle with oe_i low sets the role. Low selects head, and cfg_clk_oe_o is then 1. High selects downstream member, and cfg_clk_oe_o is then 0 and cfg_clk_o stays 0.
- R2: As head, cfg_clk_o stays high for exactly HALF_CYCLES system clocks and low for exactly HALF_CYCLES system clocks while it runs. The default of 2 gives 40 ns phases at 50 MHz.
- R3: As head, the store is read from address 0 upward. Bit k (rd_bit_i at rd_addr_o = k) is on data_o with data_oe_o = 1 during the low phase just before the (k+1)-th rising edge of cfg_clk_o.
- R4: As head, after DEPTH rising edges casc_n_o goes low and data_oe_o goes low in the same cycle, and cfg_clk_o keeps toggling while cs_n_i stays low.
- R5: If cs_n_i goes high after all DEPTH bits have gone out, the head gives exactly TAIL_CLKS (default 16) further rising edges of cfg_clk_o. It then holds cfg_clk_o low and raises no error.
- R6: If cs_n_i goes high while the head still has bits to send, err_pull_o goes to 1 and cfg_clk_o and data_oe_o go to 0 and stay there. This includes the cycle in which the final rising edge is due.
- R7: oe_i low forces cfg_clk_o to 0, data_oe_o to 0, casc_n_o to 1 and err_pull_o to 0 from the next cycle on. The address restarts at 0 when oe_i rises again.
- R8: As downstream member with cs_n_i low, each rising edge on cfg_clk_i advances one bit, starting at bit 0. After DEPTH edges casc_n_o is 0 and data_oe_o is 0.
- R9: As downstream member with cs_n_i high, edges on cfg_clk_i advance nothing and data_oe_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-up reset, active low |
| oe_i | input | 1 | Output enable; low acts as reset |
| cs_n_i | input | 1 | Chip select, active low |
| cfg_clk_i | input | 1 | Received configuration clock (downstream role) |
| cfg_clk_o | output | 1 | Generated configuration clock |
| cfg_clk_oe_o | output | 1 | Drive enable for the configuration clock |
| rd_addr_o | output | AW | Bit address into the external store |
| rd_bit_i | input | 1 | Stored bit at rd_addr_o |
| data_o | output | 1 | Serial configuration data |
| data_oe_o | output | 1 | Drive enable for data_o |
| casc_n_o | output | 1 | Cascade enable to the next source, active low |
| err_pull_o | output | 1 | 1 pulls the open-drain error line low |

## Verification
Two events can land on the same system-clock edge: the rising edge that sends the head's final bit, and the decision made on the target's chip-select release. The bench waits for a low phase of exactly HALF_CYCLES samples with one bit left. It then raises chip-select just before the edge that would send the last bit, and it expects the abort pull-down. In a second run it raises chip-select one sample after that edge and expects the exact tail burst with no error. A third case raises chip-select during the tail-phase rising edge and checks that this edge counts towards the burst.

// File: rtl/cfgsrc_pkg.sv
package cfgsrc_pkg;
    typedef enum logic [2:0] {
        ST_HOLD,
        ST_STREAM,
        ST_TAIL,
        ST_IDLE,
        ST_ABORT
    } src_state_e;
endpackage

// File: rtl/cfgsrc_clkgen.sv
module cfgsrc_clkgen #(
    parameter int HALF_CYCLES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic clk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int PW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

    typedef struct packed {
        logic [PW-1:0] ph;
        logic          lvl;
    } gen_t;

    gen_t gen_d, gen_q;
    logic ph_last;

    assign ph_last = (gen_q.ph == PW'(HALF_CYCLES - 1));

    always_comb begin
        gen_d  = gen_q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        if (!run_i) begin
            gen_d.ph  = '0;
            gen_d.lvl = 1'b0;
        end else if (ph_last) begin
            gen_d.ph  = '0;
            gen_d.lvl = !gen_q.lvl;
            rise_o    = !gen_q.lvl;
            fall_o    = gen_q.lvl;
        end else begin
            gen_d.ph = gen_q.ph + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gen_q <= '0;
        else         gen_q <= gen_d;
    end

    assign clk_o = gen_q.lvl;

    // R2: a level change while running happens only at the end of a phase
    a_r2_phase_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(run_i) && (gen_q.lvl != $past(gen_q.lvl)))
            |-> ($past(gen_q.ph) == PW'(HALF_CYCLES - 1)));
endmodule

// File: rtl/cfgsrc_edge_sync.sv
module cfgsrc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [SYNC_STAGES:0] sh;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.sh = {sy_q.sh[SYNC_STAGES-1:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sy_q <= '0;
        else         sy_q <= sy_d;
    end

    assign rise_o = sy_q.sh[SYNC_STAGES-1] & ~sy_q.sh[SYNC_STAGES];
endmodule

// File: rtl/cfgsrc_bitcnt.sv
module cfgsrc_bitcnt #(
    parameter int DEPTH = 1024,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic          done_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic          done;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (step_i && !cnt_q.done) begin
            if (cnt_q.addr == AW'(DEPTH - 1)) cnt_d.done = 1'b1;
            else                              cnt_d.addr = cnt_q.addr + AW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign addr_o = cnt_q.addr;
    assign done_o = cnt_q.done;

    // R4: exhaustion holds until the counter is cleared
    a_r4_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q.done && !clr_i) |=> cnt_q.done);
    // R3: a step before exhaustion moves to the next address or ends the store
    a_r3_step_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !clr_i && !cnt_q.done) |=> (cnt_q.done || (cnt_q.addr != $past(cnt_q.addr))));
endmodule

// File: rtl/cfg_chain_head.sv
module cfg_chain_head #(
    parameter int DEPTH       = 1024,
    parameter int HALF_CYCLES = 2,
    parameter int TAIL_CLKS   = 16,
    parameter int SYNC_STAGES = 2,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          oe_i,
    input  logic          cs_n_i,
    input  logic          cfg_clk_i,
    output logic          cfg_clk_o,
    output logic          cfg_clk_oe_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_bit_i,
    output logic          data_o,
    output logic          data_oe_o,
    output logic          casc_n_o,
    output logic          err_pull_o
);
    import cfgsrc_pkg::*;

    localparam int TW = $clog2(TAIL_CLKS + 1);

    typedef struct packed {
        src_state_e     st;
        logic           head;
        logic [TW-1:0]  tail_cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic gen_run, gen_rise, gen_fall, ext_rise, step, clr, done;

    assign gen_run = ctl_q.head && oe_i &&
                     ((ctl_q.st == ST_STREAM) || (ctl_q.st == ST_TAIL));

    cfgsrc_clkgen #(.HALF_CYCLES(HALF_CYCLES)) u_gen (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (gen_run),
        .clk_o  (cfg_clk_o),
        .rise_o (gen_rise),
        .fall_o (gen_fall)
    );

    cfgsrc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (cfg_clk_i),
        .rise_o  (ext_rise)
    );

    assign clr  = (ctl_q.st == ST_HOLD);
    assign step = (ctl_q.st == ST_STREAM) && oe_i &&
                  (ctl_q.head ? gen_rise : (ext_rise && !cs_n_i));

    cfgsrc_bitcnt #(.DEPTH(DEPTH)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr),
        .step_i (step),
        .addr_o (rd_addr_o),
        .done_o (done)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (!oe_i) begin
            ctl_d.st       = ST_HOLD;
            ctl_d.head     = !cs_n_i;
            ctl_d.tail_cnt = '0;
        end else begin
            unique case (ctl_q.st)
                ST_HOLD: ctl_d.st = ST_STREAM;
                ST_STREAM: begin
                    if (ctl_q.head && cs_n_i) begin
                        if (done) begin
                            ctl_d.st       = ST_TAIL;
                            ctl_d.tail_cnt = gen_rise ? TW'(1) : '0;
                        end else begin
                            ctl_d.st = ST_ABORT;
                        end
                    end
                end
                ST_TAIL: begin
                    if (gen_rise) ctl_d.tail_cnt = ctl_q.tail_cnt + TW'(1);
                    if (gen_fall && (ctl_q.tail_cnt == TW'(TAIL_CLKS)))
                        ctl_d.st = ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '{st: ST_HOLD, head: 1'b0, tail_cnt: '0};
        else         ctl_q <= ctl_d;
    end

    assign cfg_clk_oe_o = ctl_q.head;
    assign data_oe_o    = oe_i && (ctl_q.st == ST_STREAM) && !cs_n_i && !done;
    assign data_o       = data_oe_o ? rd_bit_i : 1'b0;
    assign casc_n_o     = !(oe_i && done && (ctl_q.st != ST_HOLD));
    assign err_pull_o   = (ctl_q.st == ST_ABORT);

    // R7: output-enable low quiets every output on the next cycle
    a_r7_oe_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !oe_i |=> (!cfg_clk_o && !data_oe_o && casc_n_o && !err_pull_o));
    // R6: after an abort the clock and the data stay silent
    a_r6_abort_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_ABORT) |=> (!cfg_clk_o && !data_oe_o));
    // R5: idle keeps the clock parked low
    a_r5_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_IDLE) |=> !cfg_clk_o);
    // R5: the burst counter never passes its limit
    a_r5_tail_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_q.tail_cnt <= TW'(TAIL_CLKS));
    // R4: cascade handoff never overlaps own data drive
    a_r4_casc_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !casc_n_o |-> !data_oe_o);
    // R1: a downstream member leaves the clock low
    a_r1_follower_no_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_clk_oe_o |-> !cfg_clk_o);
endmodule

// File: tb/cfg_chain_head_tb_top.sv
module cfg_chain_head_tb_top;
    localparam int DEPTH = 24;
    localparam int HALF  = 2;
    localparam int TAIL  = 16;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oe = 1'b0;
    logic cs_n = 1'b0;
    logic ext_clk = 1'b0;
    logic cfg_clk, cfg_clk_oe, dout, doe, casc_n, err_pull;
    logic [AW-1:0] addr;
    logic rbit;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int rises = 0;
    int lowrun = 0;
    int hirun = 0;
    int ph_bad = 0;
    int bit_bad = 0;
    bit pclk = 0;
    bit pdoe = 0;
    bit pdat = 0;
    bit collect = 0;

    always #10 clk = ~clk;

    function automatic logic pat(input int k);
        return logic'(((k * 7) >> 2) ^ k);
    endfunction

    assign rbit = pat(int'(addr));

    cfg_chain_head #(.DEPTH(DEPTH), .HALF_CYCLES(HALF), .TAIL_CLKS(TAIL)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .oe_i(oe), .cs_n_i(cs_n), .cfg_clk_i(ext_clk),
        .cfg_clk_o(cfg_clk), .cfg_clk_oe_o(cfg_clk_oe), .rd_addr_o(addr),
        .rd_bit_i(rbit), .data_o(dout), .data_oe_o(doe), .casc_n_o(casc_n),
        .err_pull_o(err_pull)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one sample per system clock, away from the active edge
    task automatic tick();
        @(negedge clk);
        if (cfg_clk && !pclk) begin
            if (collect && rises < DEPTH)
                if (!(pdoe && pdat == pat(rises))) bit_bad++;
            if (collect && lowrun != HALF && rises > 0) ph_bad++;
            rises++;
            hirun = 1;
            lowrun = 0;
        end else if (!cfg_clk && pclk) begin
            if (collect && hirun != HALF) ph_bad++;
            lowrun = 1;
            hirun = 0;
        end else if (cfg_clk) hirun++;
        else lowrun++;
        pclk = cfg_clk;
        pdoe = doe;
        pdat = dout;
    endtask

    task automatic head_start();
        oe = 1'b0;
        cs_n = 1'b0;
        repeat (3) tick();
        oe = 1'b1;
        rises = 0;
        lowrun = 0;
        hirun = 0;
        collect = 1;
    endtask

    task automatic wait_rises(input int n);
        int guard = 0;
        while (rises < n && guard < 2000) begin
            tick();
            guard++;
        end
    endtask

    task automatic ext_pulse();
        repeat (4) @(negedge clk);
        ext_clk = 1'b1;
        repeat (4) @(negedge clk);
        ext_clk = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int base;
        int quiet;
        // reset state
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (2) tick();
        check(!cfg_clk && !doe && casc_n && !err_pull, "R7 reset state",
              {cfg_clk, doe, casc_n, err_pull}, 4'b0010);

        // full head run with handoff and tail
        head_start();
        tick();
        check(cfg_clk_oe == 1'b1, "R1 head drives clock", cfg_clk_oe, 1);
        wait_rises(DEPTH);
        tick();
        check(bit_bad == 0, "R3 head bit order", bit_bad, 0);
        check(!casc_n && !doe, "R4 handoff", {casc_n, doe}, 0);
        base = rises;
        wait_rises(base + 4);
        check(rises == base + 4, "R4 clock continues", rises - base, 4);
        check(ph_bad == 0, "R2 phase lengths", ph_bad, 0);
        cs_n = 1'b1;
        base = rises;
        quiet = 0;
        for (int i = 0; i < 400 && quiet < 40; i++) begin
            tick();
            if (cfg_clk) quiet = 0; else quiet++;
        end
        check(rises - base == TAIL, "R5 tail burst count", rises - base, TAIL);
        check(!err_pull && !cfg_clk, "R5 idle no error", {err_pull, cfg_clk}, 0);

        // output-enable reset mid-stream, then restart at bit 0
        head_start();
        wait_rises(5);
        oe = 1'b0;
        tick();
        check(!cfg_clk && !doe && casc_n, "R7 oe low quiets", {cfg_clk, doe, casc_n}, 1);
        head_start();
        wait_rises(3);
        check(bit_bad == 0, "R7 restart from bit 0", bit_bad, 0);

        // premature stop
        head_start();
        wait_rises(6);
        cs_n = 1'b1;
        repeat (2) tick();
        check(err_pull == 1'b1, "R6 early abort flagged", err_pull, 1);
        base = rises;
        repeat (20) tick();
        check(rises == base && !doe && !cfg_clk, "R6 abort silent", rises - base, 0);
        oe = 1'b0;
        tick();
        check(!err_pull, "R7 error cleared", err_pull, 0);

        // chip-select release in the cycle of the final rising edge
        head_start();
        wait_rises(DEPTH - 1);
        while (!(lowrun == HALF && !cfg_clk)) tick();
        cs_n = 1'b1;
        repeat (3) tick();
        check(err_pull == 1'b1, "R6 release on final edge aborts", err_pull, 1);
        repeat (4) tick();
        check(!cfg_clk, "R6 clock low after abort", cfg_clk, 0);

        // chip-select release one sample after the final edge
        head_start();
        wait_rises(DEPTH);
        cs_n = 1'b1;
        base = rises;
        quiet = 0;
        for (int i = 0; i < 400 && quiet < 40; i++) begin
            tick();
            if (cfg_clk) quiet = 0; else quiet++;
        end
        check(rises - base == TAIL && !err_pull, "R5 release after final edge",
              rises - base, TAIL);

        // chip-select release during the tail-phase rising edge: that edge counts
        head_start();
        wait_rises(DEPTH + 2);
        while (!(lowrun == HALF && !cfg_clk)) tick();
        cs_n = 1'b1;
        base = rises;
        quiet = 0;
        for (int i = 0; i < 400 && quiet < 40; i++) begin
            tick();
            if (cfg_clk) quiet = 0; else quiet++;
        end
        check(rises - base == TAIL, "R5 edge coinciding with release counts",
              rises - base, TAIL);

        // downstream member
        collect = 0;
        oe = 1'b0;
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        oe = 1'b1;
        repeat (2) @(negedge clk);
        check(!cfg_clk_oe && !cfg_clk, "R1 downstream role", {cfg_clk_oe, cfg_clk}, 0);
        for (int i = 0; i < 5; i++) ext_pulse();
        check(!doe && casc_n, "R9 idle while deselected", {doe, casc_n}, 1);
        cs_n = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            repeat (3) @(negedge clk);
            check(doe && dout == pat(k), "R8 downstream bit", {doe, dout}, {1'b1, pat(k)});
            ext_pulse();
        end
        repeat (6) @(negedge clk);
        check(!casc_n && !doe, "R8 downstream handoff", {casc_n, doe}, 0);
        check(!cfg_clk, "R1 downstream never clocks", cfg_clk, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule